// File: doc/BRIEF.md
# Latched-Address Flash Bus Front-End

This block is the device-side bus interface of a parallel NOR-style memory whose address is loaded through a separate latch strobe. It runs on a fast internal clock. Five asynchronous active-low control pins are chip enable, write enable, output enable, latch enable and a hardware reset. Each passes through a two-flop synchronizer before any edge is detected. The address and data buses are staged alongside the pins, so they stay aligned with the pins in time. From the synchronized pins the block decodes the current bus operation and drives the data-bus output enable. It loads the address on a latch-enable rising edge. For every accepted write it emits a one-cycle command strobe carrying the latched address and the captured data word.

A write is the overlap of chip enable low and write enable low, with output enable and latch enable high. The write ends on whichever of the two strobes rises first, and the later rise of the same cycle is ignored. An overlap that was not held for MIN_LOW_CYC sampled cycles is treated as a glitch and dropped. A write is also dropped if output enable, latch enable or reset leave their required levels before it ends. The hardware reset pin overrides everything else.

Every output is registered. It reflects the pins as they were sampled three clock edges earlier: two synchronizer stages plus one output register.

Top module: `flash_bus_frontend`

## Requirements
- R1: `op_state` shows the decoded operation, with this priority: reset pin low = 0, chip enable high (standby) = 1, output enable low (read) = 2, latch enable low (address latch) = 3, write enable low (write) = 4, otherwise output disable = 5. After reset it reads 1.
- R2: `dq_drive_en` is 1 only while the decoded operation is read (code 2). It is 0 whenever output enable is high.
- R3: A latch-enable rising edge with chip enable low and the reset pin high loads `latched_addr` with the address bus value present when the rising latch enable is first sampled.
- R4: Latch-enable pulses while chip enable is high leave `latched_addr` unchanged.
- R5: A qualified write produces exactly one `cmd_stb` pulse, on the rising edge of write enable or chip enable, whichever comes first. During that pulse `cmd_addr` holds the latched address and `cmd_data` holds the data bus value sampled at that edge. The later rising edge of the same write adds no second pulse.
- R6: A chip-enable/write-enable overlap shorter than MIN_LOW_CYC sampled cycles produces no strobe. An overlap of exactly MIN_LOW_CYC cycles produces one.
- R7: No strobe results when latch enable is low during the write, when latch enable drops in the middle of a write, or when output enable is low.
- R8: While the reset pin is low, `op_state` is 0, `latched_addr` is cleared to 0, `dq_drive_en` is 0 and no strobe is produced.
- R9: In standby (chip enable held high), write-enable pulses produce no strobe and `dq_drive_en` stays 0 even with output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously upstream |
| bus_ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| bus_we_n | input | 1 | Write enable pin, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable pin, active low, asynchronous |
| bus_le_n | input | 1 | Address latch enable pin, active low, asynchronous |
| bus_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| bus_addr | input | ADDR_W | Address bus |
| bus_din | input | DATA_W | Incoming data bus |
| op_state | output | 3 | Decoded bus operation code |
| dq_drive_en | output | 1 | Enable for the data output driver |
| latched_addr | output | ADDR_W | Most recently latched address |
| cmd_stb | output | 1 | One-cycle strobe per accepted write |
| cmd_addr | output | ADDR_W | Address belonging to the strobed write |
| cmd_data | output | DATA_W | Data belonging to the strobed write |

## Verification
The assertions assume that the address and data buses are stable from before the relevant strobe rises until that rise has crossed the synchronizer. They also assume that each pin level lasts at least one clock, so the two-flop chain never hides a full pulse. The stimulus meets both conditions: it changes the pins only on falling clock edges, one step at a time, and it changes the buses only while no strobe edge is pending. Because the properties relate the synchronized pin levels to the registered outputs one cycle later, they rely on the synchronizer resetting every pin to its inactive level.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_READ    = 3'd2,
    OP_LATCH   = 3'd3,
    OP_WRITE   = 3'd4,
    OP_OUTDIS  = 3'd5
  } bus_op_e;

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fbf_pulse_qual.sv
module fbf_pulse_qual #(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic keep,
  output logic end_ok
);

  generate
    if (MIN_CYC <= 1) begin : g_edge
      logic seen_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= level;
      end

      assign end_ok = seen_q && !level && keep;
    end else begin : g_count
      localparam int            CW   = $clog2(MIN_CYC + 1);
      localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);
      logic [CW-1:0] run_q;
      logic [CW-1:0] run_d;

      always_comb begin
        if (!level)             run_d = '0;
        else if (run_q != CMAX) run_d = run_q + CW'(1);
        else                    run_d = run_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
      end

      assign end_ok = (run_q == CMAX) && !level && keep;
    end
  endgenerate

  AST_END_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    end_ok |-> $past(level)); // R6

endmodule

// File: rtl/fbf_op_decode.sv
module fbf_op_decode
  import fbf_pkg::*;
(
  input  logic    ce_n,
  input  logic    we_n,
  input  logic    oe_n,
  input  logic    le_n,
  input  logic    hw_rst_n,
  output bus_op_e op
);

  always_comb begin
    if (!hw_rst_n)  op = OP_RESET;
    else if (ce_n)  op = OP_STANDBY;
    else if (!oe_n) op = OP_READ;
    else if (!le_n) op = OP_LATCH;
    else if (!we_n) op = OP_WRITE;
    else            op = OP_OUTDIS;
  end

endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import fbf_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 16,
  parameter int MIN_LOW_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic              bus_le_n,
  input  logic              bus_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [2:0]        op_state,
  output logic              dq_drive_en,
  output logic [ADDR_W-1:0] latched_addr,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int NPIN  = 5;
  localparam int BUS_W = ADDR_W + DATA_W;
  localparam int LE_MIN = 1;

  // synchronized pins, inactive (high) out of reset
  logic [NPIN-1:0] pin_s;
  logic [BUS_W-1:0] bus_s;
  logic ce_s, we_s, oe_s, le_s, rp_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  fbf_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL({NPIN{1'b1}})) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_rst_n, bus_le_n, bus_oe_n, bus_we_n, bus_ce_n}),
    .q     (pin_s)
  );

  fbf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_addr, bus_din}),
    .q     (bus_s)
  );

  assign ce_s   = pin_s[0];
  assign we_s   = pin_s[1];
  assign oe_s   = pin_s[2];
  assign le_s   = pin_s[3];
  assign rp_s   = pin_s[4];
  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  // write window: overlap of chip enable and write enable under legal side levels
  logic wr_level, wr_keep, wr_evt;
  assign wr_level = !ce_s && !we_s && oe_s && le_s && rp_s;
  assign wr_keep  = oe_s && le_s && rp_s;

  fbf_pulse_qual #(.MIN_CYC(MIN_LOW_CYC)) u_wr_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (wr_level),
    .keep   (wr_keep),
    .end_ok (wr_evt)
  );

  // address window: latch enable low with chip selected
  logic al_level, al_keep, al_evt;
  assign al_level = !ce_s && !le_s && rp_s;
  assign al_keep  = !ce_s && rp_s;

  fbf_pulse_qual #(.MIN_CYC(LE_MIN)) u_al_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (al_level),
    .keep   (al_keep),
    .end_ok (al_evt)
  );

  bus_op_e op_cur;

  fbf_op_decode u_decode (
    .ce_n     (ce_s),
    .we_n     (we_s),
    .oe_n     (oe_s),
    .le_n     (le_s),
    .hw_rst_n (rp_s),
    .op       (op_cur)
  );

  // next-state
  bus_op_e           op_q, op_d;
  logic              drv_q, drv_d;
  logic [ADDR_W-1:0] lat_q, lat_d;
  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] caddr_q;
  logic [DATA_W-1:0] cdata_q;
  logic              cmd_en;

  always_comb begin
    op_d   = op_cur;
    drv_d  = (op_cur == OP_READ);
    stb_d  = wr_evt;
    cmd_en = wr_evt;
    if (!rp_s)       lat_d = '0;
    else if (al_evt) lat_d = addr_s;
    else             lat_d = lat_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_STANDBY;
      drv_q <= 1'b0;
      lat_q <= '0;
      stb_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      drv_q <= drv_d;
      lat_q <= lat_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q <= '0;
      cdata_q <= '0;
    end else if (cmd_en) begin
      caddr_q <= lat_q;
      cdata_q <= data_s;
    end
  end

  assign op_state     = op_q;
  assign dq_drive_en  = drv_q;
  assign latched_addr = lat_q;
  assign cmd_stb      = stb_q;
  assign cmd_addr     = caddr_q;
  assign cmd_data     = cdata_q;

  AST_DRIVE_OFF_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    oe_s |=> !dq_drive_en); // R2

  AST_LE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && rp_s) |=> $stable(latched_addr)); // R4

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R5

  AST_NO_STB_LE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> !cmd_stb); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_s |=> (!cmd_stb && latched_addr == '0 && !dq_drive_en)); // R8

  AST_STANDBY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && $past(ce_s)) |=> !cmd_stb); // R9

endmodule

// File: tb/test_flash_bus_frontend.sv
module test_flash_bus_frontend;
  import fbf_pkg::*;

  localparam int AW   = 22;
  localparam int DW   = 16;
  localparam int MINC = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic ce, we, oe, le, rp;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [2:0]    op_state;
  logic          dq_drive_en, cmd_stb;
  logic [AW-1:0] latched_addr, cmd_addr;
  logic [DW-1:0] cmd_data;

  flash_bus_frontend #(.ADDR_W(AW), .DATA_W(DW), .MIN_LOW_CYC(MINC)) i_flash_bus_frontend (
    .clk(clk), .rst_n(rst_n),
    .bus_ce_n(ce), .bus_we_n(we), .bus_oe_n(oe), .bus_le_n(le), .bus_rst_n(rp),
    .bus_addr(addr), .bus_din(din),
    .op_state(op_state), .dq_drive_en(dq_drive_en), .latched_addr(latched_addr),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit s_ce, s_we, s_oe, s_le, s_rp;
  bit f_ce, f_we, f_oe, f_le, f_rp;
  logic [AW-1:0] s_addr, f_addr;
  logic [DW-1:0] s_data, f_data;
  int wrun, arun;
  int e_op;
  bit e_oe, e_stb;
  logic [AW-1:0] e_lat, e_waddr;
  logic [DW-1:0] e_wdata;

  always @(posedge clk or negedge rst_n) begin
    bit w, a;
    if (!rst_n) begin
      {s_ce, s_we, s_oe, s_le, s_rp} = 5'b11111;
      {f_ce, f_we, f_oe, f_le, f_rp} = 5'b11111;
      s_addr = '0; f_addr = '0; s_data = '0; f_data = '0;
      wrun = 0; arun = 0;
      e_op = 1; e_oe = 0; e_stb = 0;
      e_lat = '0; e_waddr = '0; e_wdata = '0;
    end else begin
      w = !s_ce && !s_we && s_oe && s_le && s_rp;
      a = !s_ce && !s_le && s_rp;
      e_stb = !w && (wrun >= MINC) && s_oe && s_le && s_rp;
      if (e_stb) begin
        e_waddr = e_lat;
        e_wdata = s_data;
      end
      if (!s_rp) e_lat = '0;
      else if (!a && arun >= 1 && !s_ce) e_lat = s_addr;
      if (!s_rp)      e_op = 0;
      else if (s_ce)  e_op = 1;
      else if (!s_oe) e_op = 2;
      else if (!s_le) e_op = 3;
      else if (!s_we) e_op = 4;
      else            e_op = 5;
      e_oe = (e_op == 2);
      wrun = w ? ((wrun < MINC) ? wrun + 1 : wrun) : 0;
      arun = a ? 1 : 0;
      {s_ce, s_we, s_oe, s_le, s_rp} = {f_ce, f_we, f_oe, f_le, f_rp};
      s_addr = f_addr; s_data = f_data;
      {f_ce, f_we, f_oe, f_le, f_rp} = {ce, we, oe, le, rp};
      f_addr = addr; f_data = din;
    end
  end

  // every-cycle comparison, away from the active edge
  int stb_seen = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 op_state", 64'(op_state), 64'(e_op));
      chk("R2 dq_drive_en", 64'(dq_drive_en), 64'(e_oe));
      chk("R3 latched_addr", 64'(latched_addr), 64'(e_lat));
      chk("R5 cmd_stb", 64'(cmd_stb), 64'(e_stb));
      if (cmd_stb) begin
        chk("R5 cmd_addr", 64'(cmd_addr), 64'(e_waddr));
        chk("R5 cmd_data", 64'(cmd_data), 64'(e_wdata));
        stb_seen++;
        last_addr = cmd_addr;
        last_data = cmd_data;
      end
    end
  end

  task automatic setp(bit c, bit w, bit o, bit l, bit r);
    @(negedge clk);
    ce = c; we = w; oe = o; le = l; rp = r;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [AW-1:0] A1 = 22'h2A5C3;
  localparam logic [AW-1:0] A2 = 22'h15A3C;
  localparam logic [DW-1:0] D1 = 16'hBEEF;
  localparam logic [DW-1:0] D2 = 16'h1234;
  localparam logic [DW-1:0] D3 = 16'h0F0F;

  initial begin
    rst_n = 1'b0;
    {ce, we, oe, le, rp} = 5'b11111;
    addr = '0; din = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 reset op", 64'(op_state), 64'(OP_STANDBY));
    chk("R2 reset drive", 64'(dq_drive_en), 64'd0);
    chk("R8 reset addr", 64'(latched_addr), 64'd0);

    // address latch
    addr = A1;
    setp(0, 1, 1, 0, 1); idle(4);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R3 latch A1", 64'(latched_addr), 64'(A1));

    // plain write ended by write enable
    din = D1;
    setp(0, 0, 1, 1, 1); idle(5);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R5 write count", 64'(stb_seen), 64'd1);
    chk("R5 write addr", 64'(last_addr), 64'(A1));
    chk("R5 write data", 64'(last_data), 64'(D1));

    // write ended by chip enable, later write enable rise ignored
    din = D2;
    setp(0, 0, 1, 1, 1); idle(5);
    setp(1, 0, 1, 1, 1); idle(3);
    setp(1, 1, 1, 1, 1); idle(6);
    chk("R5 ce-first count", 64'(stb_seen), 64'd2);
    chk("R5 ce-first data", 64'(last_data), 64'(D2));
    setp(0, 1, 1, 1, 1); idle(3);

    // glitch below threshold, then exactly at threshold
    din = D3;
    setp(0, 0, 1, 1, 1); idle(MINC - 2);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R6 short glitch", 64'(stb_seen), 64'd2);
    setp(0, 0, 1, 1, 1); idle(MINC - 1);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R6 exact threshold", 64'(stb_seen), 64'd3);
    chk("R6 exact data", 64'(last_data), 64'(D3));

    // latch enable low during the write
    setp(0, 1, 1, 0, 1);
    setp(0, 0, 1, 0, 1); idle(5);
    setp(0, 1, 1, 0, 1);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R7 le low write", 64'(stb_seen), 64'd3);
    // latch enable drops mid-write
    setp(0, 0, 1, 1, 1); idle(4);
    setp(0, 0, 1, 0, 1); idle(2);
    setp(0, 1, 1, 0, 1); idle(2);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R7 le drop write", 64'(stb_seen), 64'd3);
    // output enable low with write enable low
    setp(0, 1, 0, 1, 1);
    setp(0, 0, 0, 1, 1); idle(5);
    setp(0, 1, 0, 1, 1);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R7 oe low write", 64'(stb_seen), 64'd3);

    // decode and drive
    setp(0, 1, 0, 1, 1); idle(5);
    chk("R2 read drive", 64'(dq_drive_en), 64'd1);
    chk("R1 read op", 64'(op_state), 64'(OP_READ));
    setp(0, 1, 1, 1, 1); idle(5);
    chk("R2 oe high drive", 64'(dq_drive_en), 64'd0);
    chk("R1 outdis op", 64'(op_state), 64'(OP_OUTDIS));
    setp(0, 1, 1, 0, 1); idle(5);
    chk("R1 latch op", 64'(op_state), 64'(OP_LATCH));
    setp(0, 1, 1, 1, 1); idle(3);
    setp(0, 0, 1, 1, 1); idle(5);
    chk("R1 write op", 64'(op_state), 64'(OP_WRITE));
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R5 fourth write", 64'(stb_seen), 64'd4);

    // standby
    setp(1, 1, 1, 1, 1);
    addr = A2;
    setp(1, 1, 1, 0, 1); idle(4);
    setp(1, 1, 1, 1, 1); idle(6);
    chk("R4 le with ce high", 64'(latched_addr), 64'(A1));
    setp(1, 0, 1, 1, 1); idle(5);
    setp(1, 1, 1, 1, 1); idle(6);
    chk("R9 standby write", 64'(stb_seen), 64'd4);
    setp(1, 1, 0, 1, 1); idle(5);
    chk("R9 standby drive", 64'(dq_drive_en), 64'd0);
    chk("R1 standby op", 64'(op_state), 64'(OP_STANDBY));
    setp(1, 1, 1, 1, 1); idle(3);

    // hardware reset pin
    setp(0, 1, 1, 0, 1); idle(3);
    setp(0, 1, 1, 1, 1); idle(6);
    chk("R3 latch A2", 64'(latched_addr), 64'(A2));
    setp(0, 1, 0, 1, 0); idle(5);
    chk("R8 reset op", 64'(op_state), 64'(OP_RESET));
    chk("R8 reset drive", 64'(dq_drive_en), 64'd0);
    chk("R8 reset clears addr", 64'(latched_addr), 64'd0);
    setp(0, 1, 1, 1, 0);
    setp(0, 0, 1, 1, 0); idle(5);
    setp(0, 1, 1, 1, 0); idle(6);
    chk("R8 reset write", 64'(stb_seen), 64'd4);
    setp(0, 1, 1, 1, 1); idle(5);
    chk("R8 addr after reset", 64'(latched_addr), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule